// File: doc/BRIEF.md
# Byte-Memory Background DMA Engine

This engine copies blocks of words between an 8-bit external byte memory and a processor's internal memories: 24-bit program memory or 16-bit data memory. It runs beside the processor and takes one internal memory cycle per word. Software sets it up through four memory-mapped registers: internal address, external address, control and word count. Writing a non-zero word count starts a block. The engine then strobes the byte memory once per byte, with a programmable number of wait cycles on each strobe. It packs or unpacks the bytes in one of four formats and exchanges each assembled word with internal memory through a request/grant handshake. It raises a one-cycle completion interrupt when the count reaches zero.

Other users of the external bus win over the engine through a busy input. A context flag in the control register can hold the processor off for the whole block and then request a restart at internal address 0. A strap sampled during reset selects a boot preset: 32 program words, loaded from page 0 with 7 wait cycles, with the processor held off.

The sequencer has four states. IDLE waits for a start. BYTE performs byte strobes. MEM waits for an internal memory grant. FINISH issues the interrupt for one cycle.

The transitions are:
- IDLE→BYTE on a start in load direction.
- IDLE→MEM on a start in store direction.
- BYTE→MEM after the last byte of a loaded word, or after the last byte of a stored word when more words remain.
- BYTE→FINISH after the last byte of the final stored word.
- MEM→BYTE on a grant when bytes are next.
- MEM→FINISH on the grant of the final loaded word.
- BYTE/MEM→FINISH on an abort.
- FINISH→IDLE always.

Top module: `bmdma_engine`

## Requirements
- R1: At reset, control (offset 2) reads 0x0078 and both address registers read 0. In the control register, bits 1:0 are the format, bit 2 the direction, bit 3 the context flag, bits 6:4 the wait count and bits 15:8 the page. With `boot_load`=1, count (offset 3) starts at 32 and a 32-word load begins unprompted. With `boot_load`=0, count is 0 and the engine stays idle.
- R2: Writing a non-zero value to offset 3 while idle starts a block. The count drops by one per word. When the block ends, `done_irq` pulses for one cycle and the count reads 0.
- R3: Format 00 loads three bytes per word, most significant byte at the lowest byte address, into a 24-bit word with `mem_pm`=1.
- R4: Format 01 loads two bytes per word, most significant byte first, into a 16-bit data word with `mem_pm`=0.
- R5: Format 10 places one byte in bits 15:8 of a data word. Format 11 places it in bits 7:0. The other half is zero.
- R6: With direction bit = 1 the engine reads internal words and writes their bytes to byte memory, in the same order and taken from the same fields as R3–R5.
- R7: With wait count w and an immediate grant, each byte strobe lasts w+1 cycles and each word costs bytes×(w+1)+1 cycles. `done_irq` appears in the cycle after the last word.
- R8: While `ext_busy` is high, neither byte strobe is driven. The block resumes afterwards, lengthened by the stalled cycles.
- R9: `mem_req` stays high, with address and write data stable, until `mem_gnt`. No interrupt is raised before that grant.
- R10: Writing 1 to offset 3 during a block ends it at once. The count reads 0, `done_irq` pulses and no further strobe or request follows.
- R11: The external pointer {page, external address} steps once per byte, carrying from the external address into the page. The internal address steps once per word. Both read back their final values.
- R12: Writes to offsets 0, 1 and 2 during a block are ignored.
- R13: With the context flag set, `core_hold` is high through the whole block. `core_restart` pulses together with `done_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_load | input | 1 | Boot strap, sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 internal, 1 external, 2 control, 3 count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| bm_addr | output | 22 | Byte memory address {page, external address} |
| bm_rd | output | 1 | Byte memory read strobe |
| bm_wr | output | 1 | Byte memory write strobe |
| bm_wdata | output | 8 | Byte written to byte memory |
| bm_rdata | input | 8 | Byte read from byte memory |
| ext_busy | input | 1 | External bus taken by a higher-precedence user |
| mem_req | output | 1 | Internal memory request |
| mem_gnt | input | 1 | Internal memory grant |
| mem_pm | output | 1 | 1 selects program memory, 0 data memory |
| mem_we | output | 1 | 1 writes internal memory, 0 reads |
| mem_addr | output | 14 | Internal word address |
| mem_wdata | output | 24 | Word written to internal memory |
| mem_rdata | input | 24 | Word read from internal memory |
| done_irq | output | 1 | Completion interrupt pulse |
| core_hold | output | 1 | Holds processor execution |
| core_restart | output | 1 | Requests a restart at internal address 0 |

## Verification
The bench builds the engine with its default parameters: 14-bit internal and external addresses, a 14-bit count and a 32-word boot preset. The 14-bit external address lets a two-byte word started at 0x3FFF show the carry into the page. The 32-word preset at 7 waits gives a full boot block of 800 cycles that fits well inside the run. The bench grants internal memory immediately, so the cycle cost of R7 can be compared exactly. It also stalls the grant and the external bus to check R8 and R9.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int PAGE_W = 8;

    typedef enum logic [1:0] {
        FMT_PM24 = 2'b00,
        FMT_DM16 = 2'b01,
        FMT_HI8  = 2'b10,
        FMT_LO8  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BYTE,
        S_MEM,
        S_FINISH
    } state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              rsvd;
        logic [2:0]        waits;
        logic              ctx;
        logic              dir;
        fmt_e              fmt;
    } ctrl_t;

    localparam logic [1:0] OFS_IADDR = 2'd0;
    localparam logic [1:0] OFS_EADDR = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_COUNT = 2'd3;

    function automatic logic [1:0] fmt_bytes(input fmt_e f);
        unique case (f)
            FMT_PM24: fmt_bytes = 2'd3;
            FMT_DM16: fmt_bytes = 2'd2;
            default:  fmt_bytes = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int IADDR_W    = 14,
    parameter int EADDR_W    = 14,
    parameter int CNT_W      = 14,
    parameter int BOOT_WORDS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      boot_load,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_addr,
    input  logic [15:0]               reg_wdata,
    output logic [15:0]               reg_rdata,
    input  logic                      busy,
    input  logic                      active,
    input  logic                      int_inc,
    input  logic                      ext_inc,
    input  logic                      word_done,
    output ctrl_t                     ctrl,
    output logic [IADDR_W-1:0]        int_addr,
    output logic [PAGE_W+EADDR_W-1:0] bm_ptr,
    output logic [CNT_W-1:0]          count,
    output logic                      count_last,
    output logic                      start,
    output logic                      abort
);
    localparam logic [CNT_W-1:0] BOOT_CNT = CNT_W'(BOOT_WORDS);

    ctrl_t              ctrl_q;
    logic [IADDR_W-1:0] int_q;
    logic [EADDR_W-1:0] ext_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               boot_go;
    logic               wr_cnt;
    logic               cfg_ok;

    assign wr_cnt = reg_wr && (reg_addr == OFS_COUNT);
    assign cfg_ok = reg_wr && !busy;
    assign start  = boot_go || (wr_cnt && !busy && (reg_wdata[CNT_W-1:0] != '0));
    assign abort  = wr_cnt && active && (reg_wdata == 16'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '{page: '0, rsvd: 1'b0, waits: 3'd7, ctx: 1'b1, dir: 1'b0, fmt: FMT_PM24};
            int_q   <= '0;
            ext_q   <= '0;
            cnt_q   <= boot_load ? BOOT_CNT : '0;
            boot_go <= boot_load;
        end else begin
            boot_go <= 1'b0;
            if (cfg_ok && reg_addr == OFS_CTRL) begin
                ctrl_q      <= ctrl_t'(reg_wdata);
                ctrl_q.rsvd <= 1'b0;
            end
            if (cfg_ok && reg_addr == OFS_IADDR) int_q <= reg_wdata[IADDR_W-1:0];
            else if (int_inc)                    int_q <= int_q + 1'b1;
            if (cfg_ok && reg_addr == OFS_EADDR) ext_q <= reg_wdata[EADDR_W-1:0];
            else if (ext_inc)                    {ctrl_q.page, ext_q} <= {ctrl_q.page, ext_q} + 1'b1;
            if (abort)                           cnt_q <= '0;
            else if (wr_cnt && !busy)            cnt_q <= reg_wdata[CNT_W-1:0];
            else if (word_done)                  cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_IADDR: reg_rdata = 16'(int_q);
            OFS_EADDR: reg_rdata = 16'(ext_q);
            OFS_CTRL:  reg_rdata = ctrl_q;
            default:   reg_rdata = 16'(cnt_q);
        endcase
    end

    assign ctrl       = ctrl_q;
    assign int_addr   = int_q;
    assign bm_ptr     = {ctrl_q.page, ext_q};
    assign count      = cnt_q;
    assign count_last = (cnt_q == CNT_W'(1));

    // R2: one word completed lowers the count by exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !abort) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R12: the internal address does not move during a block except by stepping
    p_frozen_iaddr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !int_inc) |=> $stable(int_q));

endmodule

// File: rtl/bmdma_pack.sv
module bmdma_pack
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fmt_e        fmt,
    input  logic        byte_cap,
    input  logic [7:0]  bm_rdata,
    input  logic        word_cap,
    input  logic [23:0] mem_rdata,
    input  logic [1:0]  bidx,
    output logic [1:0]  nbytes,
    output logic [23:0] wr_word,
    output logic [7:0]  out_byte
);
    logic [23:0] acc;
    logic [23:0] hold;
    logic [1:0]  shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            hold <= '0;
        end else begin
            if (byte_cap) acc  <= {acc[15:0], bm_rdata};
            if (word_cap) hold <= mem_rdata;
        end
    end

    assign nbytes = fmt_bytes(fmt);

    always_comb begin
        unique case (fmt)
            FMT_PM24: wr_word = acc;
            FMT_DM16: wr_word = {8'h00, acc[15:0]};
            FMT_HI8:  wr_word = {8'h00, acc[7:0], 8'h00};
            default:  wr_word = {16'h0000, acc[7:0]};
        endcase
    end

    always_comb begin
        unique case (fmt)
            FMT_PM24: shift = 2'd2 - bidx;
            FMT_DM16: shift = 2'd1 - bidx;
            FMT_HI8:  shift = 2'd1;
            default:  shift = 2'd0;
        endcase
        unique case (shift)
            2'd2:    out_byte = hold[23:16];
            2'd1:    out_byte = hold[15:8];
            default: out_byte = hold[7:0];
        endcase
    end

endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       dir,
    input  logic [2:0] waits,
    input  logic [1:0] nbytes,
    input  logic       count_last,
    input  logic       ext_busy,
    input  logic       mem_gnt,
    output logic       bm_rd,
    output logic       bm_wr,
    output logic       mem_req,
    output logic       mem_we,
    output logic       byte_cap,
    output logic       ext_inc,
    output logic       int_inc,
    output logic       word_done,
    output logic       word_cap,
    output logic [1:0] bidx,
    output logic       busy,
    output logic       active,
    output logic       done_irq
);
    state_e     state, state_nx;
    logic [2:0] wcnt;
    logic [1:0] bidx_q;
    logic       strobe_ok;
    logic       byte_end;
    logic       last_byte;
    logic       grant;

    assign strobe_ok = (state == S_BYTE) && !ext_busy;
    assign byte_end  = strobe_ok && (wcnt == waits);
    assign last_byte = (bidx_q == nbytes - 2'd1);
    assign grant     = (state == S_MEM) && mem_gnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            wcnt   <= '0;
            bidx_q <= '0;
        end else begin
            state <= state_nx;
            if (state != S_BYTE || abort) wcnt <= '0;
            else if (byte_end)            wcnt <= '0;
            else if (!ext_busy)           wcnt <= wcnt + 1'b1;
            if (state == S_IDLE || abort) bidx_q <= '0;
            else if (byte_end)            bidx_q <= last_byte ? 2'd0 : bidx_q + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = dir ? S_MEM : S_BYTE;
            S_BYTE:   if (byte_end && last_byte)
                          state_nx = (dir && count_last) ? S_FINISH : (dir ? S_MEM : S_MEM);
            S_MEM:    if (grant)
                          state_nx = (!dir && count_last) ? S_FINISH : S_BYTE;
            S_FINISH: state_nx = S_IDLE;
        endcase
        if (abort && (state == S_BYTE || state == S_MEM)) state_nx = S_FINISH;
    end

    always_comb begin
        bm_rd     = strobe_ok && !dir;
        bm_wr     = strobe_ok && dir;
        mem_req   = (state == S_MEM);
        mem_we    = !dir;
        byte_cap  = byte_end && !dir;
        ext_inc   = byte_end;
        int_inc   = grant;
        word_cap  = grant && dir;
        word_done = dir ? (byte_end && last_byte) : grant;
        busy      = (state != S_IDLE);
        active    = (state == S_BYTE) || (state == S_MEM);
        done_irq  = (state == S_FINISH);
        bidx      = bidx_q;
    end

    // R8: no byte strobe while the external bus is taken
    p_yield_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_busy |-> (!bm_rd && !bm_wr));

    // R9: an ungranted request is held
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort) |=> mem_req);

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int IADDR_W    = 14,
    parameter int EADDR_W    = 14,
    parameter int CNT_W      = 14,
    parameter int BOOT_WORDS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       boot_load,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_addr,
    input  logic [15:0]                reg_wdata,
    output logic [15:0]                reg_rdata,
    output logic [PAGE_W+EADDR_W-1:0]  bm_addr,
    output logic                       bm_rd,
    output logic                       bm_wr,
    output logic [7:0]                 bm_wdata,
    input  logic [7:0]                 bm_rdata,
    input  logic                       ext_busy,
    output logic                       mem_req,
    input  logic                       mem_gnt,
    output logic                       mem_pm,
    output logic                       mem_we,
    output logic [IADDR_W-1:0]         mem_addr,
    output logic [23:0]                mem_wdata,
    input  logic [23:0]                mem_rdata,
    output logic                       done_irq,
    output logic                       core_hold,
    output logic                       core_restart
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count;
    logic             count_last, start, abort;
    logic             busy, active;
    logic             int_inc, ext_inc, word_done, word_cap, byte_cap;
    logic [1:0]       bidx, nbytes;

    bmdma_regs #(
        .IADDR_W(IADDR_W), .EADDR_W(EADDR_W), .CNT_W(CNT_W), .BOOT_WORDS(BOOT_WORDS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_load(boot_load),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .active(active), .int_inc(int_inc), .ext_inc(ext_inc),
        .word_done(word_done), .ctrl(ctrl), .int_addr(mem_addr), .bm_ptr(bm_addr),
        .count(count), .count_last(count_last), .start(start), .abort(abort)
    );

    bmdma_pack u_pack (
        .clk(clk), .rst_n(rst_n), .fmt(ctrl.fmt),
        .byte_cap(byte_cap), .bm_rdata(bm_rdata),
        .word_cap(word_cap), .mem_rdata(mem_rdata),
        .bidx(bidx), .nbytes(nbytes), .wr_word(mem_wdata), .out_byte(bm_wdata)
    );

    bmdma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .dir(ctrl.dir), .waits(ctrl.waits), .nbytes(nbytes), .count_last(count_last),
        .ext_busy(ext_busy), .mem_gnt(mem_gnt),
        .bm_rd(bm_rd), .bm_wr(bm_wr), .mem_req(mem_req), .mem_we(mem_we),
        .byte_cap(byte_cap), .ext_inc(ext_inc), .int_inc(int_inc),
        .word_done(word_done), .word_cap(word_cap), .bidx(bidx),
        .busy(busy), .active(active), .done_irq(done_irq)
    );

    assign mem_pm       = (ctrl.fmt == FMT_PM24);
    assign core_hold    = ctrl.ctx && busy;
    assign core_restart = ctrl.ctx && done_irq;

    // R2: the interrupt is only raised with the count at zero
    p_irq_count_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (count == '0));

    // R9: address and data stay put while the request waits
    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R10: an abort stops strobes and requests on the next cycle
    p_abort_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!mem_req && !bm_rd && !bm_wr && done_irq));

    // R13: processor hold is released only after the interrupt cycle
    p_hold_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> $past(done_irq));

endmodule

// File: tb/test_bmdma_engine.sv
module test_bmdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_load = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [21:0] bm_addr;
    logic        bm_rd, bm_wr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        ext_busy = 1'b0;
    logic        mem_req, mem_gnt, mem_pm, mem_we;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic        done_irq, core_hold, core_restart;
    logic        gnt_stall = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0]  bmem [0:255];
    logic [23:0] pm   [0:63];
    logic [15:0] dm   [0:63];

    always #5 clk = ~clk;

    bmdma_engine i_bmdma_engine (
        .clk(clk), .rst_n(rst_n), .boot_load(boot_load),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .ext_busy(ext_busy), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_pm(mem_pm),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done_irq(done_irq), .core_hold(core_hold), .core_restart(core_restart)
    );

    assign bm_rdata  = bmem[bm_addr[7:0]];
    assign mem_gnt   = mem_req && !gnt_stall;
    assign mem_rdata = mem_pm ? pm[mem_addr[5:0]] : {8'h00, dm[mem_addr[5:0]]};

    always @(posedge clk) begin
        if (bm_wr) bmem[bm_addr[7:0]] <= bm_wdata;
        if (mem_req && mem_gnt && mem_we) begin
            if (mem_pm) pm[mem_addr[5:0]] <= mem_wdata;
            else        dm[mem_addr[5:0]] <= mem_wdata[15:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_irq(inout int cyc);
        while (!done_irq && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // writes the count, then counts negedges until done_irq is seen
    task automatic launch(input logic [15:0] cnt, output int cyc);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = cnt;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        cyc = 1;
        wait_irq(cyc);
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] ia, input logic [15:0] ea);
        wr(2'd2, c); wr(2'd0, ia); wr(2'd1, ea);
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0; boot_load = boot;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_boot;
        int cyc = 0;
        int unheld = 0;
        logic [15:0] v;
        do_reset(1'b1);
        while (!done_irq && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (!done_irq && !core_hold) unheld++;
        end
        chk(cyc == 801, "R1 boot block length", cyc, 801);
        chk(core_restart == 1'b1, "R13 restart with irq", core_restart, 1);
        chk(unheld == 0, "R13 hold through block", unheld, 0);
        chk(pm[0] == {bmem[0], bmem[1], bmem[2]}, "R1 boot word 0", pm[0], {bmem[0], bmem[1], bmem[2]});
        chk(pm[31] == {bmem[93], bmem[94], bmem[95]}, "R1 boot word 31", pm[31], {bmem[93], bmem[94], bmem[95]});
        @(negedge clk);
        chk(core_hold == 1'b0, "R13 hold released", core_hold, 0);
        rd(2'd3, v);
        chk(v == 16'd0, "R2 count zero after boot", v, 0);
    endtask

    task automatic t_reset_vals;
        logic [15:0] v;
        int strobes = 0;
        do_reset(1'b0);
        rd(2'd2, v); chk(v == 16'h0078, "R1 control preset", v, 16'h0078);
        rd(2'd0, v); chk(v == 16'h0, "R1 internal address preset", v, 0);
        rd(2'd1, v); chk(v == 16'h0, "R1 external address preset", v, 0);
        rd(2'd3, v); chk(v == 16'h0, "R1 count zero without boot", v, 0);
        repeat (10) begin
            @(negedge clk);
            if (bm_rd || mem_req) strobes++;
        end
        chk(strobes == 0, "R1 idle without boot", strobes, 0);
    endtask

    task automatic t_load24;
        int cyc;
        logic [15:0] v;
        setup(16'h0010, 16'd4, 16'h0010);
        launch(16'd2, cyc);
        chk(cyc == 15, "R7 two 3-byte words at 1 wait", cyc, 15);
        chk(pm[4] == {bmem[16], bmem[17], bmem[18]}, "R3 pm word 4", pm[4], {bmem[16], bmem[17], bmem[18]});
        chk(pm[5] == {bmem[19], bmem[20], bmem[21]}, "R3 pm word 5", pm[5], {bmem[19], bmem[20], bmem[21]});
        rd(2'd0, v); chk(v == 16'd6, "R11 internal address final", v, 6);
        rd(2'd1, v); chk(v == 16'h0016, "R11 external address final", v, 16'h16);
        rd(2'd3, v); chk(v == 16'd0, "R2 count zero at end", v, 0);
    endtask

    task automatic t_load16;
        int cyc;
        setup(16'h0001, 16'd8, 16'h0020);
        launch(16'd2, cyc);
        chk(cyc == 7, "R7 two 2-byte words at 0 waits", cyc, 7);
        chk(dm[8] == {bmem[32], bmem[33]}, "R4 dm word 8", dm[8], {bmem[32], bmem[33]});
        chk(dm[9] == {bmem[34], bmem[35]}, "R4 dm word 9", dm[9], {bmem[34], bmem[35]});
    endtask

    task automatic t_load8;
        int cyc;
        dm[12] = 16'hFFFF; dm[13] = 16'hFFFF;
        setup(16'h0022, 16'd12, 16'h0030);
        launch(16'd1, cyc);
        chk(cyc == 5, "R7 one byte at 2 waits", cyc, 5);
        chk(dm[12] == {bmem[48], 8'h00}, "R5 upper-half byte", dm[12], {bmem[48], 8'h00});
        setup(16'h0023, 16'd13, 16'h0031);
        launch(16'd1, cyc);
        chk(dm[13] == {8'h00, bmem[49]}, "R5 lower-half byte", dm[13], {8'h00, bmem[49]});
    endtask

    task automatic t_store;
        int cyc;
        pm[20] = 24'hA1B2C3; dm[21] = 16'h5E6F; dm[22] = 16'h1234;
        setup(16'h0004, 16'd20, 16'h0040);
        launch(16'd1, cyc);
        chk(cyc == 5, "R7 store word cost", cyc, 5);
        chk({bmem[64], bmem[65], bmem[66]} == 24'hA1B2C3, "R6 store 3 bytes",
            {bmem[64], bmem[65], bmem[66]}, 24'hA1B2C3);
        setup(16'h0005, 16'd21, 16'h0048);
        launch(16'd1, cyc);
        chk({bmem[72], bmem[73]} == 16'h5E6F, "R6 store 2 bytes", {bmem[72], bmem[73]}, 16'h5E6F);
        setup(16'h0006, 16'd22, 16'h0050);
        launch(16'd1, cyc);
        chk(bmem[80] == 8'h12, "R6 store upper byte", bmem[80], 8'h12);
        setup(16'h0007, 16'd22, 16'h0051);
        launch(16'd1, cyc);
        chk(bmem[81] == 8'h34, "R6 store lower byte", bmem[81], 8'h34);
    endtask

    task automatic t_busy;
        int cyc;
        int leaked = 0;
        setup(16'h0001, 16'd24, 16'h0060);
        ext_busy = 1'b1;
        wr(2'd3, 16'd1);
        cyc = 1;
        for (int i = 0; i < 3; i++) begin
            if (bm_rd || bm_wr) leaked++;
            @(negedge clk);
            cyc++;
        end
        if (bm_rd || bm_wr) leaked++;
        ext_busy = 1'b0;
        wait_irq(cyc);
        chk(leaked == 0, "R8 no strobe while bus taken", leaked, 0);
        chk(cyc == 7, "R8 block lengthened by stall", cyc, 7);
        chk(dm[24] == {bmem[96], bmem[97]}, "R8 data after stall", dm[24], {bmem[96], bmem[97]});
    endtask

    task automatic t_grant;
        int cyc = 0;
        int bad = 0;
        setup(16'h0003, 16'd14, 16'h0032);
        gnt_stall = 1'b1;
        wr(2'd3, 16'd1);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            if (!mem_req || mem_addr != 14'd14 || done_irq) bad++;
            @(negedge clk);
        end
        gnt_stall = 1'b0;
        wait_irq(cyc);
        chk(bad == 0, "R9 request held until grant", bad, 0);
        chk(done_irq == 1'b1, "R9 irq after grant", done_irq, 1);
        chk(dm[14] == {8'h00, bmem[50]}, "R9 granted word", dm[14], {8'h00, bmem[50]});
    endtask

    task automatic t_abort;
        logic [15:0] v;
        int late = 0;
        setup(16'h0070, 16'd40, 16'h0000);
        wr(2'd3, 16'd5);
        repeat (30) @(negedge clk);
        rd(2'd3, v);
        chk(v == 16'd4, "R2 count after one word", v, 4);
        wr(2'd3, 16'd1);
        #1 chk(done_irq == 1'b1, "R10 irq on abort", done_irq, 1);
        rd(2'd3, v);
        chk(v == 16'd0, "R10 count zero after abort", v, 0);
        repeat (20) begin
            @(negedge clk);
            if (bm_rd || mem_req || done_irq) late++;
        end
        chk(late == 0, "R10 nothing after abort", late, 0);
    endtask

    task automatic t_ignore;
        int cyc = 0;
        logic [15:0] v;
        setup(16'h0031, 16'd30, 16'h0080);
        wr(2'd3, 16'd2);
        wr(2'd0, 16'h3000);
        wr(2'd1, 16'h0050);
        wr(2'd2, 16'h0003);
        wait_irq(cyc);
        rd(2'd0, v); chk(v == 16'd32, "R12 internal write ignored", v, 32);
        rd(2'd1, v); chk(v == 16'h0084, "R12 external write ignored", v, 16'h84);
        rd(2'd2, v); chk(v == 16'h0031, "R12 control write ignored", v, 16'h31);
        chk(dm[31] == {bmem[130], bmem[131]}, "R12 block intact", dm[31], {bmem[130], bmem[131]});
    endtask

    task automatic t_page;
        int cyc;
        logic [15:0] v;
        setup(16'h0001, 16'd44, 16'h3FFF);
        launch(16'd1, cyc);
        chk(dm[44] == {bmem[255], bmem[0]}, "R11 word across page edge", dm[44], {bmem[255], bmem[0]});
        rd(2'd1, v); chk(v == 16'h0001, "R11 external wraps", v, 1);
        rd(2'd2, v); chk(v == 16'h0101, "R11 page carried", v, 16'h0101);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 5);
        for (int i = 0; i < 64; i++) begin pm[i] = '0; dm[i] = '0; end
        t_boot();
        t_reset_vals();
        t_load24();
        t_load16();
        t_load8();
        t_store();
        t_busy();
        t_grant();
        t_abort();
        t_ignore();
        t_page();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule